// File: doc/BRIEF.md
# Linked-List Turing Machine Stepper

This block is a hardware controller that executes a Turing machine. The program and the tape are held as chains of two-word cells in an internal 16-bit memory. Before a run, the surrounding logic (here, the testbench) builds the lists through a load port. It then gives the controller the list cell of the start state and the first tape cell, and pulses `start`. The controller walks the transition lists, compares trigger symbols with the symbol under the head, rewrites the tape and moves the head. It stops when no candidate transition is left, or when the head would leave the finite tape.

A cell is two consecutive words at an even address. The even word holds the element and the odd word holds the link to the rest of the list. A dedicated empty-list cell sits at address `NIL_CELL`. Symbols are named by the addresses of their own cells, and the first of them is the blank. A state is the list of its outgoing transitions. Each transition is a four-element list holding, in order: the trigger symbol, the replacement symbol, the direction word (bit 0: 1 = right, 0 = left) and the list cell of the successor state. The tape is kept as two stacks: the left stack holds the cells left of the head, nearest first, and the right stack holds the cells to its right.

The FSM states are IDLE, INIT (read the right-stack start), FETCH (halt test, read the transition record), TRIG, CMP, SKIP (mismatch, advance in list), W1/NSYM/W2/DIR/W3/NEXT (walk the record), WRSYM (rewrite the symbol), PUSH, POP, HALT and FAULT. A fired transition takes 12 cycles and a rejected candidate takes 4 cycles.

Top module: `tm_stepper`

## Requirements
- R1: After reset, `done` and `overflow` are 0 and `steps` is 0.
- R2: A write on the load port while no run is active stores the word, and `peek_data` returns it for `peek_addr`. A write issued while a run is in progress has no effect on memory.
- R3: When the trigger symbol of the candidate transition equals the current cell's symbol, the replacement symbol is written into that cell. The head moves one cell in the direction given by bit 0 of the direction word, and `steps` increases by exactly one.
- R4: When the trigger symbol differs, the tape is left unchanged and the next entry of the same state's list becomes the candidate.
- R5: When the candidate pointer equals `NIL_CELL`, `done` is raised and held until the next `start`, and `steps` equals the number of fired transitions. `done` and `overflow` are never high together.
- R6: If a fired transition would pop `NIL_CELL` from the stack it moves toward, the controller raises `overflow` instead. That cell's symbol is not rewritten and `steps` is not incremented.
- R7: A move left pops the nearest left cell, so a machine that sweeps right and then back left restores the marked cells in order.
- R8: A `start` accepted after a finished run clears `steps`, `done` and `overflow` on the next cycle and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_we | input | 1 | Load-port write enable |
| load_addr | input | ADDR_W | Load-port word address |
| load_data | input | DATA_W | Load-port write data |
| peek_addr | input | ADDR_W | Readback word address |
| peek_data | output | DATA_W | Readback data (combinational) |
| start | input | 1 | Begin a run (accepted when not running) |
| start_trans | input | ADDR_W | List cell of the start state |
| tape_first | input | ADDR_W | First tape cell |
| done | output | 1 | Normal halt |
| overflow | output | 1 | Head tried to leave the tape |
| steps | output | STEP_W | Fired transitions in this run |

## Verification
The hardest situations to reach are a long left sweep and a move off either end of the tape, because both need a full machine and a prepared tape in memory. The bench builds three small machines through the load port and sweeps the input length across the whole tape. The first is a right-moving filler whose first candidate misses on blank cells. The second marks cells going right and restores them going left against a start marker. The third moves left from the first cell at once. Runs with the last tape cell reached force the right-end fault.

// File: rtl/tm_pkg.sv
package tm_pkg;
    typedef enum logic [4:0] {
        S_IDLE, S_INIT, S_FETCH, S_TRIG, S_CMP, S_SKIP,
        S_W1, S_NSYM, S_W2, S_DIR, S_W3, S_NEXT,
        S_WRSYM, S_PUSH, S_POP, S_HALT, S_FAULT
    } tm_state_e;
endpackage

// File: rtl/tm_cell_ram.sv
module tm_cell_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata     = mem[addr];
    assign peek_data = mem[peek_addr];
endmodule

// File: rtl/tm_ctrl.sv
module tm_ctrl
    import tm_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 16,
    parameter int STEP_W   = 16,
    parameter int NIL_CELL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_trans,
    input  logic [ADDR_W-1:0] tape_first,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              running,
    output logic              done,
    output logic              overflow,
    output logic [STEP_W-1:0] steps
);
    localparam logic [ADDR_W-1:0] NIL = ADDR_W'(NIL_CELL);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    tm_state_e state, nstate;

    logic [ADDR_W-1:0] tp, cur, lft, rgt, walk, nxt;
    logic [DATA_W-1:0] trig, nsym;
    logic              dir;
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] pop_src;
    logic              accept;

    assign rd_ptr  = mem_rdata[ADDR_W-1:0];
    assign pop_src = dir ? rgt : lft;
    assign accept  = start && (state == S_IDLE || state == S_HALT || state == S_FAULT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE, S_HALT, S_FAULT: if (accept) nstate = S_INIT;
            S_INIT:  nstate = S_FETCH;
            S_FETCH: nstate = (tp == NIL) ? S_HALT : S_TRIG;
            S_TRIG:  nstate = S_CMP;
            S_CMP:   nstate = (mem_rdata == trig) ? S_W1 : S_SKIP;
            S_SKIP:  nstate = S_FETCH;
            S_W1:    nstate = S_NSYM;
            S_NSYM:  nstate = S_W2;
            S_W2:    nstate = S_DIR;
            S_DIR:   nstate = S_W3;
            S_W3:    nstate = S_NEXT;
            S_NEXT:  nstate = (pop_src == NIL) ? S_FAULT : S_WRSYM;
            S_WRSYM: nstate = S_PUSH;
            S_PUSH:  nstate = S_POP;
            S_POP:   nstate = S_FETCH;
            default: nstate = S_IDLE;
        endcase
    end

    // outputs: memory request and flags
    always_comb begin
        mem_addr  = cur;
        mem_we    = 1'b0;
        mem_wdata = nsym;
        unique case (state)
            S_INIT:                 mem_addr = cur | ONE;
            S_FETCH:                mem_addr = tp;
            S_TRIG, S_NSYM, S_DIR, S_NEXT: mem_addr = walk;
            S_CMP:                  mem_addr = cur;
            S_SKIP:                 mem_addr = tp | ONE;
            S_W1, S_W2, S_W3:       mem_addr = walk | ONE;
            S_WRSYM: begin
                mem_addr  = cur;
                mem_we    = 1'b1;
                mem_wdata = nsym;
            end
            S_PUSH: begin
                mem_addr  = cur | ONE;
                mem_we    = 1'b1;
                mem_wdata = DATA_W'(dir ? lft : rgt);
            end
            S_POP:                  mem_addr = pop_src | ONE;
            default:                mem_addr = cur;
        endcase
        running  = !(state == S_IDLE || state == S_HALT || state == S_FAULT);
        done     = (state == S_HALT);
        overflow = (state == S_FAULT);
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp <= NIL; cur <= NIL; lft <= NIL; rgt <= NIL;
            walk <= NIL; nxt <= NIL; trig <= '0; nsym <= '0;
            dir <= 1'b0; steps <= '0;
        end else begin
            unique case (state)
                S_IDLE, S_HALT, S_FAULT: if (accept) begin
                    tp    <= start_trans;
                    cur   <= tape_first;
                    lft   <= NIL;
                    steps <= '0;
                end
                S_INIT:  rgt  <= rd_ptr;
                S_FETCH: walk <= rd_ptr;
                S_TRIG:  trig <= mem_rdata;
                S_SKIP:  tp   <= rd_ptr;
                S_W1, S_W2, S_W3: walk <= rd_ptr;
                S_NSYM:  nsym <= mem_rdata;
                S_DIR:   dir  <= mem_rdata[0];
                S_NEXT:  nxt  <= rd_ptr;
                S_PUSH: begin
                    if (dir) lft <= cur;
                    else     rgt <= cur;
                end
                S_POP: begin
                    cur <= pop_src;
                    if (dir) rgt <= rd_ptr;
                    else     lft <= rd_ptr;
                    tp    <= nxt;
                    steps <= steps + STEP_W'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tm_stepper.sv
module tm_stepper #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 16,
    parameter int STEP_W   = 16,
    parameter int NIL_CELL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_trans,
    input  logic [ADDR_W-1:0] tape_first,
    output logic              done,
    output logic              overflow,
    output logic [STEP_W-1:0] steps
);
    logic [ADDR_W-1:0] c_addr, m_addr;
    logic              c_we, m_we, running;
    logic [DATA_W-1:0] c_wdata, m_wdata, m_rdata;

    // external writes reach memory only while the controller is inactive
    assign m_we    = running ? c_we    : load_we;
    assign m_addr  = running ? c_addr  : load_addr;
    assign m_wdata = running ? c_wdata : load_data;

    tm_cell_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
        .clk(clk), .we(m_we), .addr(m_addr), .wdata(m_wdata), .rdata(m_rdata),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );

    tm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W), .NIL_CELL(NIL_CELL)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_trans(start_trans),
        .tape_first(tape_first), .mem_addr(c_addr), .mem_we(c_we),
        .mem_wdata(c_wdata), .mem_rdata(m_rdata), .running(running),
        .done(done), .overflow(overflow), .steps(steps)
    );
endmodule

// File: rtl/tm_stepper_chk.sv
module tm_stepper_chk #(
    parameter int STEP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              overflow,
    input logic [STEP_W-1:0] steps
);
    p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && overflow));

    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(steps)));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !start) |=> (overflow && $stable(steps)));

    p_step_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (steps != $past(steps)) |-> (steps == $past(steps) + STEP_W'(1) || steps == '0));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (done || overflow)) |=> (steps == '0 && !done && !overflow));
endmodule

bind tm_stepper tm_stepper_chk #(.STEP_W(STEP_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .overflow(overflow), .steps(steps)
);

// File: tb/tm_stepper_tb.sv
module tm_stepper_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int SW = 16;
    localparam int NIL = 0;
    localparam int SB = 2, SX = 4, SM = 6, SG = 8;   // blank, one, mark, guard
    localparam int TAPE0 = 512;
    localparam int LEN = 8;
    localparam int RIGHT = 1, LEFT = 0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic load_we = 1'b0;
    logic [AW-1:0] load_addr = '0, peek_addr = '0, start_trans = '0, tape_first = '0;
    logic [DW-1:0] load_data = '0;
    logic [DW-1:0] peek_data;
    logic start = 1'b0;
    logic done, overflow;
    logic [SW-1:0] steps;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tm_stepper dut_i (
        .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
        .start(start), .start_trans(start_trans), .tape_first(tape_first),
        .done(done), .overflow(overflow), .steps(steps)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        load_we = 1'b1; load_addr = AW'(a); load_data = DW'(d);
        @(posedge clk); #1;
        load_we = 1'b0;
    endtask

    task automatic peek(input int a, output int v);
        peek_addr = AW'(a); #1;
        v = int'(peek_data);
    endtask

    function automatic int tcell(input int i);
        return TAPE0 + 2*(i-1);
    endfunction

    // list cell lc points to record rc; record = trig, new, dir, next state
    task automatic mk_trans(input int lc, input int lnext, input int rc,
                            input int trg, input int nsy, input int d, input int nst);
        wr(lc, rc);       wr(lc+1, lnext);
        wr(rc, trg);      wr(rc+1, rc+2);
        wr(rc+2, nsy);    wr(rc+3, rc+4);
        wr(rc+4, d);      wr(rc+5, rc+6);
        wr(rc+6, nst);    wr(rc+7, NIL);
    endtask

    task automatic load_tape(input int first_sym, input int n_fill, input int fill_sym, input int skip);
        for (int i = 1; i <= LEN; i++) begin
            int s;
            s = SB;
            if (i == 1 && skip == 1) s = first_sym;
            else if (i > skip && i <= skip + n_fill) s = fill_sym;
            wr(tcell(i), s);
            wr(tcell(i)+1, (i == LEN) ? NIL : tcell(i+1));
        end
    endtask

    task automatic run(input int q, input int intrude);
        int cnt;
        start_trans = AW'(q); tape_first = AW'(TAPE0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (intrude != 0) begin
            @(negedge clk);
            wr(900, 16'h1234);   // R2: ignored during a run
        end
        cnt = 0;
        while (!(done || overflow) && cnt < 20000) begin
            @(negedge clk); cnt++;
        end
        if (cnt >= 20000) chk(1'b0, "watchdog", cnt, 0);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
        chk(steps == '0, "R1 steps", int'(steps), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: load and readback
        wr(900, 16'h0055);
        peek(900, v);
        chk(v == 16'h0055, "R2 readback", v, 16'h0055);

        // Machine A: q0 @64 : {X->X,R,q0}, {B->X,R,NIL}
        mk_trans(64, 66, 200, SX, SX, RIGHT, 64);
        mk_trans(66, NIL, 208, SB, SX, RIGHT, NIL);
        // Machine B: q0 @68 guard/one/blank, q1 @74 mark/guard
        mk_trans(68, 70, 216, SG, SG, RIGHT, 68);
        mk_trans(70, 72, 224, SX, SM, RIGHT, 68);
        mk_trans(72, NIL, 232, SB, SB, LEFT, 74);
        mk_trans(74, 76, 240, SM, SX, LEFT, 74);
        mk_trans(76, NIL, 248, SG, SG, RIGHT, NIL);
        // Machine C: q @78 : {B->X,L,q}
        mk_trans(78, NIL, 256, SB, SX, LEFT, 78);

        // Machine A sweep: R3 write+right move, R4 mismatch on blanks, R5 halt
        for (int n = 0; n <= LEN-2; n++) begin
            load_tape(0, n, SX, 0);
            run(64, 0);
            chk(done == 1'b1, "R5 A done", int'(done), 1);
            chk(int'(steps) == n+1, "R5 A steps", int'(steps), n+1);
            for (int i = 1; i <= LEN; i++) begin
                peek(tcell(i), v);
                chk(v == ((i <= n+1) ? SX : SB), "R3 A tape", v, (i <= n+1) ? SX : SB);
            end
        end

        // R6: right end of tape
        load_tape(0, LEN-1, SX, 0);
        run(64, 0);
        chk(overflow == 1'b1 && done == 1'b0, "R6 A overflow", int'(overflow), 1);
        chk(int'(steps) == LEN-1, "R6 A steps", int'(steps), LEN-1);
        peek(tcell(LEN), v);
        chk(v == SB, "R6 A last cell kept", v, SB);

        // R8: restart clears flags and counter
        @(negedge clk); start = 1'b1; start_trans = AW'(78);
        @(negedge clk); start = 1'b0;
        chk(steps == '0 && !overflow && !done, "R8 restart", int'(steps), 0);
        while (!(done || overflow)) @(negedge clk);

        // Machine B sweep: R7 left moves restore marks, R4 mismatch walking
        for (int n = 0; n <= LEN-2; n++) begin
            load_tape(SG, n, SX, 1);
            run(68, (n == 3) ? 1 : 0);
            chk(done == 1'b1, "R7 B done", int'(done), 1);
            chk(int'(steps) == 2*n+3, "R7 B steps", int'(steps), 2*n+3);
            for (int i = 1; i <= LEN; i++) begin
                int e;
                e = (i == 1) ? SG : ((i <= n+1) ? SX : SB);
                peek(tcell(i), v);
                chk(v == e, "R7 B tape", v, e);
            end
        end
        peek(900, v);
        chk(v == 16'h0055, "R2 write during run ignored", v, 16'h0055);

        // R6: left end of tape
        load_tape(0, 0, SX, 0);
        run(78, 0);
        chk(overflow == 1'b1, "R6 C overflow", int'(overflow), 1);
        chk(steps == '0, "R6 C steps", int'(steps), 0);
        peek(tcell(1), v);
        chk(v == SB, "R6 C cell kept", v, SB);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule